// File: doc/BRIEF.md
# Programmable Tap Delay Controller

This block holds the tap setting of a 512-position output delay line and moves it on clock edges. The delay is built as a chain of registers that shift the data input on every active edge. One selectable chain position drives the delayed output, so the chosen tap sets how many extra edges of latency the data sees. The tap count is also reported to the surrounding logic.

A parameter picks one of three behaviours. In the fixed behaviour the tap stays at a preset. In the stepping behaviour the tap can move up or down by one, and a load strobe returns it to the preset. In the stepping-with-load behaviour the load strobe copies an external 9-bit value into the tap. Two more parameters choose the active clock edge and the active reset level. Reset is asynchronous and returns the tap to the preset. A hold input freezes the tap, so a calibration loop can pin the delay while it is running.

Each edge the controller decodes one action, and the tap register then applies it. The actions are KEEP (nothing requested), FROZEN (hold is high), PRESET (fixed behaviour, or load in stepping behaviour), TAKE (load in stepping-with-load behaviour), UP (step enabled with direction high) and DOWN (step enabled with direction low). Every edge moves the tap register from its current value to the value the decoded action selects.

Top module: `tdl_out_delay`

## Requirements
- R1: The tap setting, the load value and the count output are 9 bits wide and cover taps 0 to 511.
- R2: In fixed behaviour (MODE = MODE_FIXED) the tap stays at PRESET_TAP whatever the step enable, direction and load inputs do, and the count output reads 0.
- R3: In both adjustable behaviours, an active edge with step enable high adds one tap when the direction input is 1 and removes one tap when it is 0.
- R4: In stepping behaviour (MODE_VARIABLE), an active edge with load high sets the tap to PRESET_TAP.
- R5: In stepping-with-load behaviour (MODE_VARLOAD), an active edge with load high copies load_val_i into the tap.
- R6: When load and step enable are both high on one edge, the load wins and no step is applied.
- R7: Stepping up from tap 511 gives tap 0, and stepping down from tap 0 gives tap 511.
- R8: While hold_i is high, step and load requests are ignored and the tap does not change.
- R9: Reset forces the tap to PRESET_TAP and clears the delay chain at once, without waiting for a clock edge. RST_LOW = 1 makes reset active low; otherwise it is active high.
- R10: With CLK_FALLING = 1 all state updates on the falling clock edge; otherwise it updates on the rising edge.
- R11: After an active edge, dout_o equals the din_i value that was sampled T active edges before that edge, where T is the current tap. At T = 0 it is the value sampled at that edge.
- R12: In the adjustable behaviours, tap_cnt_o shows the current tap right after the edge that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; its active edge is chosen by CLK_FALLING |
| rst_i | input | 1 | Asynchronous reset; its level is chosen by RST_LOW |
| step_en_i | input | 1 | Enables a one-tap step on this edge |
| step_up_i | input | 1 | Step direction: 1 up, 0 down |
| load_i | input | 1 | Load strobe (preset or external value, depending on MODE) |
| load_val_i | input | 9 | External tap value, used in MODE_VARLOAD |
| din_i | input | 1 | Data entering the delay chain |
| hold_i | input | 1 | Freezes the tap setting |
| dout_o | output | 1 | Delayed data, taken at the selected tap |
| tap_cnt_o | output | 9 | Current tap in the adjustable behaviours, 0 in fixed behaviour |

## Verification
The bench drives the tap across both wrap boundaries, 511 to 0 and 0 to 511. A design that saturated there, or that widened the counter, would report the wrong count. It applies load and step together, and load with hold. A design with the wrong priority order would step when it should load, or would load through a freeze. Three instances run side by side with different behaviours, edges and reset levels. A design that mishandled an edge or reset polarity would update half a cycle late, or would not come out of reset. The delayed output is compared at taps 0, 3, 500 and 511 against a shift history kept in the bench, which exposes an off-by-one in the chain index.

// File: rtl/tdl_pkg.sv
`timescale 1ns/1ps
package tdl_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED    = 2'd0,
        MODE_VARIABLE = 2'd1,
        MODE_VARLOAD  = 2'd2
    } tdl_mode_e;

    typedef enum logic [2:0] {
        ACT_KEEP   = 3'd0,
        ACT_FROZEN = 3'd1,
        ACT_PRESET = 3'd2,
        ACT_TAKE   = 3'd3,
        ACT_UP     = 3'd4,
        ACT_DOWN   = 3'd5
    } tdl_act_e;

endpackage

// File: rtl/tdl_action_dec.sv
`timescale 1ns/1ps
// Decodes the per-edge request into one tap action.
// Priority: hold (R8) over load (R6) over step.
module tdl_action_dec
    import tdl_pkg::*;
#(
    parameter tdl_mode_e MODE = MODE_VARLOAD
) (
    input  logic     hold_i,
    input  logic     load_i,
    input  logic     step_en_i,
    input  logic     step_up_i,
    output tdl_act_e act_o
);

    always_comb begin
        act_o = ACT_KEEP;
        unique case (MODE)
            MODE_FIXED: begin
                // fixed behaviour pins the tap to its preset (R2)
                act_o = ACT_PRESET;
            end
            MODE_VARIABLE, MODE_VARLOAD: begin
                if (hold_i) begin
                    act_o = ACT_FROZEN;
                end else if (load_i) begin
                    act_o = (MODE == MODE_VARLOAD) ? ACT_TAKE : ACT_PRESET;
                end else if (step_en_i) begin
                    act_o = step_up_i ? ACT_UP : ACT_DOWN;
                end else begin
                    act_o = ACT_KEEP;
                end
            end
            default: begin
                act_o = ACT_PRESET;
            end
        endcase
    end

endmodule

// File: rtl/tdl_tap_reg.sv
`timescale 1ns/1ps
// Tap state register: one process for the register, one for the next value.
module tdl_tap_reg
    import tdl_pkg::*;
#(
    parameter int TAP_BITS   = 9,
    parameter int PRESET_TAP = 0
) (
    input  logic                clk_i,
    input  logic                arst_i,
    input  tdl_act_e            act_i,
    input  logic [TAP_BITS-1:0] load_val_i,
    output logic [TAP_BITS-1:0] tap_o
);

    localparam logic [TAP_BITS-1:0] PRESET_V = PRESET_TAP[TAP_BITS-1:0];
    localparam logic [TAP_BITS-1:0] ONE_V    = {{(TAP_BITS-1){1'b0}}, 1'b1};

    logic [TAP_BITS-1:0] tap_q;
    logic [TAP_BITS-1:0] tap_d;

    // state register, asynchronous return to preset (R9)
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            tap_q <= PRESET_V;
        end else begin
            tap_q <= tap_d;
        end
    end

    // next tap; UP and DOWN wrap modulo 2**TAP_BITS (R7)
    always_comb begin
        tap_d = tap_q;
        unique case (act_i)
            ACT_KEEP:   tap_d = tap_q;
            ACT_FROZEN: tap_d = tap_q;
            ACT_PRESET: tap_d = PRESET_V;
            ACT_TAKE:   tap_d = load_val_i;
            ACT_UP:     tap_d = tap_q + ONE_V;
            ACT_DOWN:   tap_d = tap_q - ONE_V;
            default:    tap_d = tap_q;
        endcase
    end

    assign tap_o = tap_q;

endmodule

// File: rtl/tdl_delay_chain.sv
`timescale 1ns/1ps
// Shift chain: position k holds the sample taken k active edges before the latest one.
module tdl_delay_chain #(
    parameter int DEPTH = 512
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic             din_i,
    output logic [DEPTH-1:0] stages_o
);

    logic [DEPTH-1:0] sh_q;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[DEPTH-2:0], din_i};
        end
    end

    assign stages_o = sh_q;

endmodule

// File: rtl/tdl_tap_sel.sv
`timescale 1ns/1ps
// Picks the chain position named by the tap.
module tdl_tap_sel #(
    parameter int TAP_BITS = 9,
    localparam int DEPTH   = 1 << TAP_BITS
) (
    input  logic [DEPTH-1:0]    stages_i,
    input  logic [TAP_BITS-1:0] tap_i,
    output logic                dout_o
);

    assign dout_o = stages_i[tap_i];

endmodule

// File: rtl/tdl_out_delay.sv
`timescale 1ns/1ps
module tdl_out_delay
    import tdl_pkg::*;
#(
    parameter tdl_mode_e MODE        = MODE_VARLOAD,
    parameter int        TAP_BITS    = 9,
    parameter int        PRESET_TAP  = 0,
    parameter bit        CLK_FALLING = 1'b0,
    parameter bit        RST_LOW     = 1'b0
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                step_en_i,
    input  logic                step_up_i,
    input  logic                load_i,
    input  logic [TAP_BITS-1:0] load_val_i,
    input  logic                din_i,
    input  logic                hold_i,
    output logic                dout_o,
    output logic [TAP_BITS-1:0] tap_cnt_o
);

    localparam int DEPTH = 1 << TAP_BITS;

    logic                eff_clk;
    logic                arst;
    tdl_act_e            act;
    logic [TAP_BITS-1:0] tap_q;
    logic [DEPTH-1:0]    stages;

    // edge selection (R10) and reset level selection (R9)
    generate
        if (CLK_FALLING) begin : g_clk_fall
            assign eff_clk = ~clk_i;
        end else begin : g_clk_rise
            assign eff_clk = clk_i;
        end
        if (RST_LOW) begin : g_rst_low
            assign arst = ~rst_i;
        end else begin : g_rst_high
            assign arst = rst_i;
        end
    endgenerate

    tdl_action_dec #(
        .MODE (MODE)
    ) u_dec (
        .hold_i    (hold_i),
        .load_i    (load_i),
        .step_en_i (step_en_i),
        .step_up_i (step_up_i),
        .act_o     (act)
    );

    tdl_tap_reg #(
        .TAP_BITS   (TAP_BITS),
        .PRESET_TAP (PRESET_TAP)
    ) u_tap (
        .clk_i      (eff_clk),
        .arst_i     (arst),
        .act_i      (act),
        .load_val_i (load_val_i),
        .tap_o      (tap_q)
    );

    tdl_delay_chain #(
        .DEPTH (DEPTH)
    ) u_chain (
        .clk_i    (eff_clk),
        .arst_i   (arst),
        .din_i    (din_i),
        .stages_o (stages)
    );

    tdl_tap_sel #(
        .TAP_BITS (TAP_BITS)
    ) u_sel (
        .stages_i (stages),
        .tap_i    (tap_q),
        .dout_o   (dout_o)
    );

    // count is reported only in the adjustable behaviours (R2, R12)
    generate
        if (MODE == MODE_FIXED) begin : g_cnt_off
            assign tap_cnt_o = '0;
        end else begin : g_cnt_on
            assign tap_cnt_o = tap_q;
        end
    endgenerate

endmodule

// File: rtl/tdl_out_delay_chk.sv
`timescale 1ns/1ps
module tdl_out_delay_chk
    import tdl_pkg::*;
#(
    parameter tdl_mode_e MODE       = MODE_VARLOAD,
    parameter int        TAP_BITS   = 9,
    parameter int        PRESET_TAP = 0
) (
    input logic                clk_i,
    input logic                arst_i,
    input logic                hold_i,
    input logic                load_i,
    input logic                step_en_i,
    input logic                step_up_i,
    input logic [TAP_BITS-1:0] load_val_i,
    input logic                din_i,
    input logic                dout_i,
    input logic [TAP_BITS-1:0] tap_i,
    input logic [TAP_BITS-1:0] cnt_i
);

    localparam logic [TAP_BITS-1:0] PRESET_V = PRESET_TAP[TAP_BITS-1:0];
    localparam bit ADJ = (MODE != MODE_FIXED);

    // R2: fixed behaviour reports zero and keeps the preset
    p_fixed_quiet_r2: assert property (@(posedge clk_i) disable iff (arst_i)
        (!ADJ) |-> (cnt_i == '0 && tap_i == PRESET_V));

    // R3: step up
    p_step_up_r3: assert property (@(posedge clk_i) disable iff (arst_i)
        (ADJ && !hold_i && !load_i && step_en_i && step_up_i)
        |=> tap_i == TAP_BITS'($past(tap_i) + 1'b1));

    // R3: step down
    p_step_down_r3: assert property (@(posedge clk_i) disable iff (arst_i)
        (ADJ && !hold_i && !load_i && step_en_i && !step_up_i)
        |=> tap_i == TAP_BITS'($past(tap_i) - 1'b1));

    // R7: wrap from the top tap
    p_wrap_top_r7: assert property (@(posedge clk_i) disable iff (arst_i)
        (ADJ && !hold_i && !load_i && step_en_i && step_up_i && tap_i == '1)
        |=> tap_i == '0);

    // R4: load restores the preset in stepping behaviour
    p_load_preset_r4: assert property (@(posedge clk_i) disable iff (arst_i)
        (MODE == MODE_VARIABLE && !hold_i && load_i) |=> tap_i == PRESET_V);

    // R5 and R6: load copies the external value, even with a step request
    p_load_take_r5: assert property (@(posedge clk_i) disable iff (arst_i)
        (MODE == MODE_VARLOAD && !hold_i && load_i) |=> tap_i == $past(load_val_i));

    // R8: hold freezes the tap
    p_hold_freeze_r8: assert property (@(posedge clk_i) disable iff (arst_i)
        (ADJ && hold_i) |=> $stable(tap_i));

    // R11: at tap 0 the output is the sample taken at the latest edge
    p_zero_tap_data_r11: assert property (@(posedge clk_i) disable iff (arst_i)
        1'b1 |=> (tap_i != '0 || dout_i == $past(din_i)));

endmodule

bind tdl_out_delay tdl_out_delay_chk #(
    .MODE       (MODE),
    .TAP_BITS   (TAP_BITS),
    .PRESET_TAP (PRESET_TAP)
) u_chk (
    .clk_i      (eff_clk),
    .arst_i     (arst),
    .hold_i     (hold_i),
    .load_i     (load_i),
    .step_en_i  (step_en_i),
    .step_up_i  (step_up_i),
    .load_val_i (load_val_i),
    .din_i      (din_i),
    .dout_i     (dout_o),
    .tap_i      (tap_q),
    .cnt_i      (tap_cnt_o)
);

// File: tb/tb_tdl_out_delay.sv
`timescale 1ns/1ps
module tb_tdl_out_delay;
    import tdl_pkg::*;

    // stimulus word: {hold, load, step_en, step_up, din, load_val[8:0], expected dut count[8:0]}
    localparam int NVEC = 15;
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0,1'b0,1'b1,1'b1,1'b1, 9'd0,   9'd6},
        {1'b0,1'b0,1'b1,1'b1,1'b0, 9'd0,   9'd7},
        {1'b0,1'b0,1'b1,1'b0,1'b1, 9'd0,   9'd6},
        {1'b0,1'b1,1'b0,1'b0,1'b1, 9'd510, 9'd510},
        {1'b0,1'b0,1'b1,1'b1,1'b0, 9'd0,   9'd511},
        {1'b0,1'b0,1'b1,1'b1,1'b0, 9'd0,   9'd0},
        {1'b0,1'b0,1'b1,1'b0,1'b1, 9'd0,   9'd511},
        {1'b0,1'b1,1'b1,1'b1,1'b0, 9'd100, 9'd100},
        {1'b1,1'b0,1'b1,1'b1,1'b1, 9'd0,   9'd100},
        {1'b1,1'b1,1'b0,1'b0,1'b1, 9'd7,   9'd100},
        {1'b0,1'b0,1'b0,1'b1,1'b1, 9'd0,   9'd100},
        {1'b0,1'b0,1'b1,1'b0,1'b0, 9'd0,   9'd99},
        {1'b0,1'b1,1'b0,1'b0,1'b1, 9'd0,   9'd0},
        {1'b0,1'b0,1'b1,1'b0,1'b0, 9'd0,   9'd511},
        {1'b0,1'b1,1'b0,1'b0,1'b1, 9'd3,   9'd3}
    };

    localparam int P_DUT = 5;
    localparam int P_VAR = 500;
    localparam int P_FIX = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_n;
    logic       step_en = 1'b0, step_up = 1'b0, load = 1'b0, din = 1'b0, hold = 1'b0;
    logic [8:0] load_val = '0;
    logic       dout_dut, dout_var, dout_fix;
    logic [8:0] cnt_dut, cnt_var, cnt_fix;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [8:0] m_dut, m_var;
    logic [511:0] hist;

    assign rst_n = ~rst;
    always #4 clk = ~clk;

    tdl_out_delay #(.MODE(MODE_VARLOAD), .TAP_BITS(9), .PRESET_TAP(P_DUT),
                    .CLK_FALLING(1'b0), .RST_LOW(1'b0)) dut (
        .clk_i(clk), .rst_i(rst), .step_en_i(step_en), .step_up_i(step_up),
        .load_i(load), .load_val_i(load_val), .din_i(din), .hold_i(hold),
        .dout_o(dout_dut), .tap_cnt_o(cnt_dut));

    tdl_out_delay #(.MODE(MODE_VARIABLE), .TAP_BITS(9), .PRESET_TAP(P_VAR),
                    .CLK_FALLING(1'b1), .RST_LOW(1'b1)) dut_var (
        .clk_i(clk), .rst_i(rst_n), .step_en_i(step_en), .step_up_i(step_up),
        .load_i(load), .load_val_i(load_val), .din_i(din), .hold_i(hold),
        .dout_o(dout_var), .tap_cnt_o(cnt_var));

    tdl_out_delay #(.MODE(MODE_FIXED), .TAP_BITS(9), .PRESET_TAP(P_FIX),
                    .CLK_FALLING(1'b0), .RST_LOW(1'b0)) dut_fix (
        .clk_i(clk), .rst_i(rst), .step_en_i(step_en), .step_up_i(step_up),
        .load_i(load), .load_val_i(load_val), .din_i(din), .hold_i(hold),
        .dout_o(dout_fix), .tap_cnt_o(cnt_fix));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] ref_next(input bit varload, input logic [8:0] pre,
                                            input logic [8:0] cur, input bit h, input bit l,
                                            input bit c, input bit u, input logic [8:0] lv);
        if (h) return cur;
        if (l) return varload ? lv : pre;
        if (c) return u ? cur + 9'd1 : cur - 9'd1;
        return cur;
    endfunction

    task automatic check_all(input string tag);
        chk(tag, "dut count", int'(cnt_dut), int'(m_dut));
        chk("R12", "variable count", int'(cnt_var), int'(m_var));
        chk("R2", "fixed count", int'(cnt_fix), 0);
        chk("R11", "dut data", int'(dout_dut), int'(hist[m_dut]));
        chk("R11", "variable data", int'(dout_var), int'(hist[m_var]));
        chk("R2", "fixed data", int'(dout_fix), int'(hist[P_FIX]));
    endtask

    // called at posedge+1: drive, let both edges pass, check at next posedge+1
    task automatic apply(input bit h, input bit l, input bit c, input bit u,
                         input bit d, input logic [8:0] lv, input string tag);
        hold = h; load = l; step_en = c; step_up = u; din = d; load_val = lv;
        m_dut = ref_next(1'b1, 9'(P_DUT), m_dut, h, l, c, u, lv);
        m_var = ref_next(1'b0, 9'(P_VAR), m_var, h, l, c, u, lv);
        hist  = {hist[510:0], d};
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    task automatic model_reset();
        m_dut = 9'(P_DUT);
        m_var = 9'(P_VAR);
        hist  = '0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // reset state, R9
        chk("R9", "dut count in reset", int'(cnt_dut), P_DUT);
        chk("R9", "variable count in reset", int'(cnt_var), P_VAR);
        chk("R9", "fixed count in reset", int'(cnt_fix), 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_all("R9");

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [22:0] v;
            string tag;
            v = VEC[i];
            if (v[22])                     tag = "R8";
            else if (v[21] && v[20])       tag = "R6";
            else if (v[21])                tag = "R5";
            else if (v[20] && (m_dut == 9'd511 || m_dut == 9'd0)) tag = "R7";
            else                           tag = "R3";
            apply(v[22], v[21], v[20], v[19], v[18], v[17:9], tag);
            chk("R1", "table count", int'(cnt_dut), int'(v[8:0]));
            if (v[21] && !v[22]) chk("R4", "variable load to preset", int'(cnt_var), P_VAR);
        end

        // data stream at tap 3, R11
        for (int k = 0; k < 12; k++) begin
            apply(1'b0, 1'b0, 1'b0, 1'b0, bit'((k * 5 + 1) % 3 == 0), 9'd0, "R11");
        end

        // clock edge selection, R10
        hold = 1'b0; load = 1'b0; step_en = 1'b1; step_up = 1'b1; din = 1'b1;
        @(negedge clk);
        #1;
        chk("R10", "falling-edge instance moved", int'(cnt_var), int'(m_var + 9'd1));
        chk("R10", "rising-edge instance waits", int'(cnt_dut), int'(m_dut));
        m_dut = m_dut + 9'd1;
        m_var = m_var + 9'd1;
        hist  = {hist[510:0], 1'b1};
        @(posedge clk);
        #1;
        check_all("R10");
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, "R3");

        // asynchronous reset between edges, R9
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 9'd200, "R5");
        rst = 1'b1;
        #1;
        chk("R9", "dut async reset count", int'(cnt_dut), P_DUT);
        chk("R9", "variable async reset count", int'(cnt_var), P_VAR);
        chk("R9", "dut chain cleared", int'(dout_dut), 0);
        model_reset();
        @(posedge clk);
        #1;
        rst = 1'b0;
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule